// File: doc/BRIEF.md
# Microsecond Interval Timer with Expiry Triggers

This block is a bus-programmed interval timer whose time base is a one-microsecond tick. The tick comes from a built-in prescaler that divides the system clock by `CLK_HZ / 1_000_000`. Software writes an interval in microseconds and a small control word. While the timer is running, it counts ticks until the interval is reached. At that point it signals an expiry.

Each expiry can produce a one-cycle pulse toward an interrupt controller, a one-cycle pulse toward a DMA engine, or both. Each destination has its own enable. A read-only tally records how many expiries have occurred since the timer was last started.

The timer runs in one of two modes. In one-shot mode it stops itself after the first expiry. In periodic mode it reloads and keeps going. The register port is a simple 32-bit word-addressed read/write bus with combinational read data.

Top module: `usec_interval_timer`

## Requirements
- R1: After reset the control word, the interval and the expiry tally all read 0, and neither pulse output is high.
- R2: Word address 0 holds the control word, with run at bit 0, periodic at bit 1, interrupt enable at bit 2 and DMA enable at bit 3. Bits 31:4 read as 0. Word address 1 holds the interval, which reads back as written. Word address 2 returns the expiry tally.
- R3: With D = CLK_HZ/1e6 and interval N, the first expiry pulse is high for the one cycle that begins N*D-1 rising edges after the edge that captures a write setting run from 0.
- R4: In periodic mode, further expiries follow every N*D cycles, and run stays set.
- R5: In one-shot mode, exactly one expiry occurs. After it, the run bit reads 0 and no further pulses appear.
- R6: The interrupt pulse appears only when bit 2 is set, and the DMA pulse appears only when bit 3 is set. Each pulse lasts a single cycle.
- R7: Each expiry adds one to the tally. A write that takes run from 0 to 1 clears the tally and the tick progress.
- R8: An interval of 0 behaves as an interval of 1.
- R9: Writes to word address 2 leave the tally unchanged.
- R10: Clearing run stops the timer. No pulse appears afterwards, and the tally holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word address within the timer |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word |
| irqPulse | output | 1 | One-cycle interrupt request on expiry |
| dmaPulse | output | 1 | One-cycle DMA block trigger on expiry |

## Verification
A wrong prescaler phase or tick count first shows as an expiry pulse in the wrong cycle. The scoreboard compares every pulse against its exact expected cycle, so such an error is seen at the first expiry, which is at most N*D cycles after start. A tally or run bit that fails to clear, or that fails to update, is seen at the next register read. The pulses themselves also reveal it: a missing self-stop or a missed restart produces an unexpected pulse or a missing one, which the scoreboard catches before the following expiry.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
  localparam int unsigned REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_CTRL     = 2'd0,
    REG_INTERVAL = 2'd1,
    REG_COUNT    = 2'd2,
    REG_SPARE    = 2'd3
  } utmr_reg_e;

  typedef struct packed {
    logic dmaEn;
    logic irqEn;
    logic periodic;
    logic run;
  } utmr_ctrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;     // one microsecond elapsed while running
    logic restart;  // run went 0 -> 1 by a write
    logic active;   // run bit
  } utmr_strobe_t;
endpackage

// File: rtl/utmr_ctrl.sv
module utmr_ctrl
  import utmr_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned INTERVAL_W = 32,
  parameter int unsigned COUNT_W    = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic                  expire,
  input  logic [COUNT_W-1:0]    expCount,
  output utmr_strobe_t          strobe,
  output logic [INTERVAL_W-1:0] effInterval,
  output logic                  irqPulse,
  output logic                  dmaPulse
);
  localparam int unsigned DIV   = CLK_HZ / 1_000_000;
  localparam int unsigned PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  utmr_ctrl_t            ctrl;
  logic [INTERVAL_W-1:0] intervalReg;
  logic [PRE_W-1:0]      preCnt;
  logic                  wrCtrl, wrInterval, runRise, tick;

  assign wrCtrl     = busSel && busWrite && (busAddr == REG_CTRL);
  assign wrInterval = busSel && busWrite && (busAddr == REG_INTERVAL);
  assign runRise    = wrCtrl && busWdata[0] && !ctrl.run;

  // register bank: a bus write wins over the one-shot self-stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl        <= '0;
      intervalReg <= '0;
    end else begin
      if (wrCtrl) begin
        ctrl.run      <= busWdata[0];
        ctrl.periodic <= busWdata[1];
        ctrl.irqEn    <= busWdata[2];
        ctrl.dmaEn    <= busWdata[3];
      end else if (expire && !ctrl.periodic) begin
        ctrl.run <= 1'b0;
      end
      if (wrInterval) intervalReg <= busWdata[INTERVAL_W-1:0];
    end
  end

  // microsecond prescaler, phase restarts whenever the timer is idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preCnt <= '0;
    else if (!ctrl.run)        preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                       preCnt <= preCnt + PRE_W'(1);
  end

  assign tick           = ctrl.run && (preCnt == PRE_LAST);
  assign strobe.tick    = tick;
  assign strobe.restart = runRise;
  assign strobe.active  = ctrl.run;
  assign effInterval    = (intervalReg == '0) ? INTERVAL_W'(1) : intervalReg;
  assign irqPulse       = expire && ctrl.irqEn;
  assign dmaPulse       = expire && ctrl.dmaEn;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      REG_CTRL:     busRdata[3:0] = {ctrl.dmaEn, ctrl.irqEn, ctrl.periodic, ctrl.run};
      REG_INTERVAL: busRdata[INTERVAL_W-1:0] = intervalReg;
      REG_COUNT:    busRdata[COUNT_W-1:0] = expCount;
      default:      busRdata = '0;
    endcase
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_LAST); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !ctrl.periodic && !wrCtrl) |=> !ctrl.run); // R5
  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse || dmaPulse) |-> ctrl.run); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R6
endmodule

// File: rtl/utmr_datapath.sv
module utmr_datapath
  import utmr_pkg::*;
#(
  parameter int unsigned INTERVAL_W = 32,
  parameter int unsigned COUNT_W    = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  utmr_strobe_t          strobe,
  input  logic [INTERVAL_W-1:0] effInterval,
  output logic                  expire,
  output logic [COUNT_W-1:0]    expCount
);
  logic [INTERVAL_W-1:0] tickCnt, nextCnt;

  assign nextCnt = tickCnt + INTERVAL_W'(1);
  // >= covers an interval lowered below the current progress
  assign expire  = strobe.tick && (nextCnt >= effInterval);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      expCount <= '0;
    end else if (strobe.restart) begin
      tickCnt  <= '0;
      expCount <= '0;
    end else if (strobe.tick) begin
      tickCnt <= expire ? '0 : nextCnt;
      if (expire) expCount <= expCount + COUNT_W'(1);
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !strobe.restart) |=> expCount == $past(expCount) + COUNT_W'(1)); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.restart) |=> $stable(expCount)); // R10
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (expCount == '0)); // R7
endmodule

// File: rtl/usec_interval_timer.sv
module usec_interval_timer
  import utmr_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned INTERVAL_W = 32,
  parameter int unsigned COUNT_W    = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqPulse,
  output logic        dmaPulse
);
  utmr_strobe_t          strobe;
  logic [INTERVAL_W-1:0] effInterval;
  logic                  expire;
  logic [COUNT_W-1:0]    expCount;

  utmr_ctrl #(.CLK_HZ(CLK_HZ), .INTERVAL_W(INTERVAL_W), .COUNT_W(COUNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .expire(expire), .expCount(expCount), .strobe(strobe),
    .effInterval(effInterval), .irqPulse(irqPulse), .dmaPulse(dmaPulse)
  );

  utmr_datapath #(.INTERVAL_W(INTERVAL_W), .COUNT_W(COUNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effInterval(effInterval),
    .expire(expire), .expCount(expCount)
  );
endmodule

// File: tb/sim_usec_interval_timer.sv
module sim_usec_interval_timer;
  localparam int unsigned CLK_HZ = 4_000_000;
  localparam int unsigned D      = CLK_HZ / 1_000_000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqPulse, dmaPulse;

  int unsigned cyc = 0;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  typedef struct {
    int unsigned at;
    logic        irq;
    logic        dma;
    string       req;
  } exp_t;
  exp_t sbq[$];

  usec_interval_timer #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqPulse(irqPulse), .dmaPulse(dmaPulse)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [31:0] d, output int unsigned stamp);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    stamp = cyc;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectPulse(input int unsigned at, input logic irq, input logic dma, input string req);
    exp_t e;
    e.at = at; e.irq = irq; e.dma = dma; e.req = req;
    sbq.push_back(e);
  endtask

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && !done && (irqPulse || dmaPulse)) begin
      if (sbq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5/R10 unexpected pulse cycle=%0d irq=%0b dma=%0b expected none", cyc, irqPulse, dmaPulse);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(e.req, "pulse cycle", cyc, e.at);
        check("R6", "irq bit", {31'd0, irqPulse}, {31'd0, e.irq});
        check("R6", "dma bit", {31'd0, dmaPulse}, {31'd0, e.dma});
      end
    end
  end

  initial begin
    #(200_000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned s0, s1;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRd(2'd0, rd); check("R1", "ctrl after reset", rd, 32'h0);
    busRd(2'd1, rd); check("R1", "interval after reset", rd, 32'h0);
    busRd(2'd2, rd); check("R1", "count after reset", rd, 32'h0);
    check("R1", "pulses idle", {30'd0, irqPulse, dmaPulse}, 32'h0);

    // R2 interval read-back
    busWr(2'd1, 32'd5, s0);
    busRd(2'd1, rd); check("R2", "interval readback", rd, 32'd5);

    // R3/R5 one-shot, irq only, junk in upper control bits
    busWr(2'd0, 32'hABCD_0005, s0);
    expectPulse(s0 + 5*D - 1, 1'b1, 1'b0, "R3");
    busRd(2'd0, rd); check("R2", "ctrl masked readback", rd, 32'h5);
    repeat (60) @(posedge clk);
    busRd(2'd0, rd); check("R5", "run self-cleared", rd, 32'h4);
    busRd(2'd2, rd); check("R7", "count after one-shot", rd, 32'd1);

    // R4 periodic, dma only, interval 3; stop before fifth expiry
    busWr(2'd1, 32'd3, s0);
    busWr(2'd0, 32'hB, s0);
    for (int k = 1; k <= 4; k++) expectPulse(s0 + k*3*D - 1, 1'b0, 1'b1, "R4");
    repeat (50) @(posedge clk);
    busWr(2'd0, 32'hA, s1);
    busRd(2'd2, rd); check("R4", "count after four periods", rd, 32'd4);
    busRd(2'd0, rd); check("R10", "run cleared by write", rd, 32'hA);
    repeat (40) @(posedge clk);
    busRd(2'd2, rd); check("R10", "count holds while stopped", rd, 32'd4);

    // R8 interval 0 behaves as 1, both outputs enabled
    busWr(2'd1, 32'd0, s0);
    busWr(2'd0, 32'hF, s0);
    for (int k = 1; k <= 4; k++) expectPulse(s0 + k*D - 1, 1'b1, 1'b1, "R8");
    repeat (17) @(posedge clk);
    busWr(2'd0, 32'h0, s1);
    busRd(2'd2, rd); check("R8", "count with zero interval", rd, 32'd4);

    // R7 restart clears tally: interval 2, periodic irq
    busWr(2'd1, 32'd2, s0);
    busWr(2'd0, 32'h7, s0);
    for (int k = 1; k <= 2; k++) expectPulse(s0 + k*2*D - 1, 1'b1, 1'b0, "R7");
    repeat (17) @(posedge clk);
    busWr(2'd0, 32'h6, s1);
    busRd(2'd2, rd); check("R7", "count cleared on restart", rd, 32'd2);

    // R9 count ignores writes
    busWr(2'd2, 32'h1234, s0);
    busRd(2'd2, rd); check("R9", "count unchanged by write", rd, 32'd2);
    busRd(2'd1, rd); check("R9", "interval unchanged by count write", rd, 32'd2);

    repeat (20) @(posedge clk);
    check("R4", "scoreboard drained", sbq.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule